// File: doc/BRIEF.md
# Free-Run Bus Target Responder

This block is a minimal target for a 16-bit processor bus that carries address and data over the same wires. All strobes on this bus are active low. It answers every transfer at once, so the processor never stalls and never traps, and it supplies a fixed no-operation instruction word on every read. With that word on the bus, the processor fetches consecutive words forever and acts as an address counter.

The data on the shared wires is inverted, so a bus that nobody drives floats to all ones and reads as zero. The block raises the address acknowledge for as long as the bus-cycle strobe is held. It drops the reply strobe combinationally whenever a read or a write strobe appears inside a bus cycle. It keeps a copy of the address from the start of each bus cycle so that a display can show it. A sticky pass flag records that the fetch sweep has reached a chosen target address. All strobe inputs are assumed to be already synchronous to the block clock.

Top module: `bus_target_responder`

## Requirements
- R1: With `rst` high at a clock edge, `addr_latched` becomes 0x0000 and `sweep_done` becomes 0 after that edge.
- R2: `ack_addr_n` equals `cyc_n` in the same cycle, with no register in the path.
- R3: `reply_n` is 0 exactly when `cyc_n` is 0 and at least one of `rd_n` or `wr_n` is 0, and is 1 otherwise. It is combinational.
- R4: `bus_oe` is 1 exactly while `rd_n` is 0, whether `cyc_n` is high or low. It is combinational.
- R5: `bus_out` is 0xFF5F, the bit-inverted form of the no-op word 0x00A0, while `bus_oe` is 1, and 0xFFFF (the floating level) while `bus_oe` is 0.
- R6: At the first clock edge where `cyc_n` is sampled 0 after being sampled 1, `addr_latched` takes the bitwise inverse of `bus_in`. The new value is visible after that edge.
- R7: At every other edge out of reset, `addr_latched` keeps its value. This covers later edges of the same bus cycle, reads without a bus cycle, and writes.
- R8: `sweep_done` becomes 1 one edge after `addr_latched` first equals 0x00FE, and then stays 1 until reset, whatever addresses follow.
- R9: If `cyc_n` is already low when reset is released, no address is taken until `cyc_n` goes high and then falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_n | input | 1 | Bus-cycle strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 16 | Inverted address/data lines as received |
| bus_out | output | 16 | Inverted value driven onto the lines |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| reply_n | output | 1 | Transfer reply, active low |
| ack_addr_n | output | 1 | Address acknowledge, active low |
| addr_latched | output | 16 | True (non-inverted) address of the last bus cycle |
| sweep_done | output | 1 | Sticky flag: target address reached |

## Verification
On every cycle, the assertions check three things. First, the address copy changes only at the falling edge of the bus-cycle strobe and then holds the inverted bus value. Second, a read without a bus cycle leaves that copy unchanged. Third, the pass flag is sticky, and any reply or driven read during a bus cycle is consistent with the address acknowledge. The bench alone can show that the combinational outputs are correct for all eight strobe combinations and that a full fetch sweep counts the flag up at exactly the target. Only the bench can also show how the block behaves after a reset released in the middle of a bus cycle.

// File: rtl/bus_resp_pkg.sv
package bus_resp_pkg;
  localparam int BUS_W = 16;
  typedef logic [BUS_W-1:0] bus_word_t;

  typedef struct packed {
    logic cyc_n;
    logic rd_n;
    logic wr_n;
  } strobes_t;

  function automatic bus_word_t invert_word(input bus_word_t w);
    return ~w;
  endfunction
endpackage

// File: rtl/brsp_handshake.sv
module brsp_handshake
  import bus_resp_pkg::*;
(
  input  strobes_t stb,
  output logic     reply_n,
  output logic     ack_addr_n
);
  logic in_cycle;
  logic transfer_req;

  always_comb begin
    in_cycle     = ~stb.cyc_n;
    transfer_req = ~stb.rd_n | ~stb.wr_n;
    reply_n      = ~(in_cycle & transfer_req);
    ack_addr_n   = stb.cyc_n;
  end
endmodule

// File: rtl/brsp_read_drive.sv
module brsp_read_drive
  import bus_resp_pkg::*;
#(
  parameter int        W        = BUS_W,
  parameter bus_word_t NOP_WORD = 16'h00A0
) (
  input  logic         rd_n,
  output logic [W-1:0] bus_out,
  output logic         bus_oe
);
  localparam logic [W-1:0] DRIVEN_VAL = ~NOP_WORD[W-1:0];
  localparam logic [W-1:0] FLOAT_VAL  = {W{1'b1}};

  always_comb begin
    bus_oe  = ~rd_n;
    bus_out = bus_oe ? DRIVEN_VAL : FLOAT_VAL;
  end
endmodule

// File: rtl/brsp_addr_capture.sv
module brsp_addr_capture
  import bus_resp_pkg::*;
#(
  parameter int W = BUS_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cyc_n,
  input  logic         rd_n,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] addr_q
);
  logic cyc_n_prev;
  logic start_edge;

  assign start_edge = cyc_n_prev & ~cyc_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_n_prev <= 1'b0;
      addr_q     <= '0;
    end else begin
      cyc_n_prev <= cyc_n;
      if (start_edge) addr_q <= ~bus_in;
    end
  end

  assert_capture_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(cyc_n) && !cyc_n) |=> (addr_q == ~$past(bus_in)));

  assert_hold_otherwise_R7: assert property (@(posedge clk) disable iff (rst)
    !($past(cyc_n) && !cyc_n) |=> $stable(addr_q));

  assert_no_capture_cycleless_read_R7: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && cyc_n) |=> $stable(addr_q));
endmodule

// File: rtl/brsp_pass_monitor.sv
module brsp_pass_monitor
  import bus_resp_pkg::*;
#(
  parameter int           W      = BUS_W,
  parameter logic [W-1:0] TARGET = 16'h00FE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] addr_q,
  output logic         done
);
  logic hit;
  assign hit = (addr_q == TARGET);

  always_ff @(posedge clk) begin
    if (rst)      done <= 1'b0;
    else if (hit) done <= 1'b1;
  end

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_done_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (addr_q == TARGET) |=> done);
endmodule

// File: rtl/bus_target_responder.sv
module bus_target_responder
  import bus_resp_pkg::*;
#(
  parameter int        W        = BUS_W,
  parameter bus_word_t NOP_WORD = 16'h00A0,
  parameter bus_word_t TARGET   = 16'h00FE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cyc_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic         reply_n,
  output logic         ack_addr_n,
  output logic [W-1:0] addr_latched,
  output logic         sweep_done
);
  strobes_t stb;
  assign stb = '{cyc_n: cyc_n, rd_n: rd_n, wr_n: wr_n};

  brsp_handshake u_hs (
    .stb        (stb),
    .reply_n    (reply_n),
    .ack_addr_n (ack_addr_n)
  );

  brsp_read_drive #(.W(W), .NOP_WORD(NOP_WORD)) u_rd (
    .rd_n    (rd_n),
    .bus_out (bus_out),
    .bus_oe  (bus_oe)
  );

  brsp_addr_capture #(.W(W)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .cyc_n  (cyc_n),
    .rd_n   (rd_n),
    .bus_in (bus_in),
    .addr_q (addr_latched)
  );

  brsp_pass_monitor #(.W(W), .TARGET(TARGET[W-1:0])) u_pass (
    .clk    (clk),
    .rst    (rst),
    .addr_q (addr_latched),
    .done   (sweep_done)
  );

  assert_reply_within_ack_R3: assert property (@(posedge clk) disable iff (rst)
    !reply_n |-> !ack_addr_n);

  assert_read_in_cycle_replies_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && !ack_addr_n) |-> !reply_n);

  assert_driven_word_R5: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (bus_out == ~NOP_WORD[W-1:0]));
endmodule

// File: tb/bus_target_responder_test.sv
module bus_target_responder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] bus_in = 16'hFFFF;
  logic [15:0] bus_out, addr_latched;
  logic        bus_oe, reply_n, ack_addr_n, sweep_done;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bus_target_responder uut (
    .clk(clk), .rst(rst), .cyc_n(cyc_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .reply_n(reply_n),
    .ack_addr_n(ack_addr_n), .addr_latched(addr_latched), .sweep_done(sweep_done)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // advance one clock edge; return at the following falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // check all combinational outputs against the strobe values
  task automatic chk_comb();
    logic exp_rply, exp_oe;
    #1;
    exp_rply = !(!cyc_n && (!rd_n || !wr_n));
    exp_oe   = !rd_n;
    chk({15'd0, ack_addr_n}, {15'd0, cyc_n}, "R2 ack follows cycle strobe");
    chk({15'd0, reply_n}, {15'd0, exp_rply}, "R3 reply");
    chk({15'd0, bus_oe}, {15'd0, exp_oe}, "R4 drive enable");
    chk(bus_out, exp_oe ? 16'hFF5F : 16'hFFFF, "R5 driven word");
  endtask

  // one fetch: cycle start with address, then read, then release
  task automatic fetch(input logic [15:0] a);
    cyc_n = 1'b0; bus_in = ~a;
    chk_comb();
    tick();
    chk(addr_latched, a, "R6 address taken at cycle start");
    bus_in = 16'h1234; rd_n = 1'b0;
    chk_comb();
    tick();
    chk(addr_latched, a, "R7 address held during read");
    rd_n = 1'b1; cyc_n = 1'b1;
    chk_comb();
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    chk(addr_latched, 16'h0000, "R1 address after reset");
    chk({15'd0, sweep_done}, 16'd0, "R1 flag after reset");
    rst = 1'b0;
    @(negedge clk);

    // R2..R5: all eight strobe combinations, no clocked effect intended
    for (int k = 0; k < 8; k++) begin
      cyc_n = 1'b1; rd_n = k[1]; wr_n = k[2];
      chk_comb();
      tick();
    end
    for (int k = 0; k < 8; k++) begin
      cyc_n = k[0]; rd_n = k[1]; wr_n = k[2];
      chk_comb();
    end
    cyc_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    tick();

    // R7: read without bus cycle (start-vector fetch) must not capture
    bus_in = 16'h0000; rd_n = 1'b0;
    chk_comb();
    tick();
    chk(addr_latched, 16'h0000, "R7 no capture on cycle-less read");
    rd_n = 1'b1;
    tick();

    // write cycle: capture, then data phase leaves address alone
    cyc_n = 1'b0; bus_in = ~16'h0BEE;
    tick();
    chk(addr_latched, 16'h0BEE, "R6 capture on write cycle");
    wr_n = 1'b0; bus_in = 16'h0F0F;
    chk_comb();
    tick();
    chk(addr_latched, 16'h0BEE, "R7 held during write data");
    wr_n = 1'b1; cyc_n = 1'b1;
    tick();
    chk({15'd0, sweep_done}, 16'd0, "R8 flag clear before target");

    // sweep fetch addresses 0..0xFC: flag must stay clear
    for (int a = 0; a < 16'hFE; a += 2) begin
      fetch(a[15:0]);
      chk({15'd0, sweep_done}, 16'd0, "R8 flag clear below target");
    end
    // reach target: flag rises one edge after the address shows it
    cyc_n = 1'b0; bus_in = ~16'h00FE;
    tick();
    chk(addr_latched, 16'h00FE, "R6 target captured");
    chk({15'd0, sweep_done}, 16'd0, "R8 flag not yet set");
    tick();
    chk({15'd0, sweep_done}, 16'd1, "R8 flag set one edge later");
    cyc_n = 1'b1;
    tick();
    for (int a = 16'h100; a < 16'h110; a += 2) fetch(a[15:0]);
    chk({15'd0, sweep_done}, 16'd1, "R8 flag sticky past target");

    // R9: cycle strobe low across reset release
    cyc_n = 1'b0; bus_in = ~16'h4444; rst = 1'b1;
    tick();
    chk({15'd0, sweep_done}, 16'd0, "R1 flag cleared by reset");
    chk(addr_latched, 16'h0000, "R1 address cleared by reset");
    rst = 1'b0;
    tick(); tick();
    chk(addr_latched, 16'h0000, "R9 no capture while low from reset");
    cyc_n = 1'b1;
    tick();
    cyc_n = 1'b0; bus_in = ~16'h5555;
    tick();
    chk(addr_latched, 16'h5555, "R9 capture after fresh fall");
    cyc_n = 1'b1;
    tick();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule